// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

This block is one timer channel that produces a pulse-width modulated output. A 16-bit counter counts up from zero to a programmable modulo and then restarts. A power-of-two prescaler sets how often it advances. The output goes high when the counter restarts and low once the counter reaches a channel match value, so the fraction of time spent high follows the match value.

Software does not write the match value directly. It writes a duty request together with a resolution in bits. The block scales the request onto the counter range as `(duty * (modulo + 1)) >> resolution`. A request of 0 therefore keeps the line low, and a request of `2^resolution` keeps it high, whatever modulo is chosen.

A newly scaled match value is held in a shadow register. It is adopted only when the counter wraps, so a period already in progress is never cut short.

Top module: `pwm_timer_chan`

## Requirements
- R1: While enabled, the counter advances by one on each prescaled tick. On a tick with the counter at or above the modulo, it returns to 0. One period lasts (modulo+1) ticks.
- R2: The prescale field PS selects one tick every 2^PS clock cycles, for PS = 0..7. With PS = 2, a period lasts 4*(modulo+1) clock cycles.
- R3: While enabled, the output is high exactly while the counter is below the active match value. It therefore rises when the counter restarts and falls when the counter equals the match value.
- R4: The active match value is min((duty*(modulo+1)) >> resolution, 2^17-1). The register write port decodes address 0 as modulo (data bits 15:0), address 1 as control (bit 0 enable, bits 3:1 prescale), address 2 as duty (bits 16:0) and address 3 as resolution (bits 4:0).
- R5: A duty of 0 keeps the output low for the whole period.
- R6: A duty of 2^resolution keeps the output high for the whole period.
- R7: When the scaled match value exceeds the modulo, the output stays high for the whole period.
- R8: A duty written while enabled takes effect only at the next counter wrap. The current period keeps its old falling point.
- R9: While disabled, the counter and prescaler are held at 0 and the output is low. Reset leaves the block disabled with modulo 0xFFFF, prescale 0, duty 0 and resolution 8. Enabling starts a period with the counter at 0 and the match value computed from the current settings.
- R10: With resolution 8, modulo 61439 and prescale 0, a duty of 64 gives a match value of 15360. That is 15360 high cycles in every 61440-cycle period (25 %).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 17 | Register write data |
| pwm_o | output | 1 | PWM output line |

## Verification
On every cycle, the assertions check the following: the line is low while the channel is off, the counter steps by one or wraps to zero, the match value stays frozen between wraps, a zero match keeps the line low, an over-range match keeps it high, and the output rises only at a counter restart. Other properties depend on the settings and are shown only by the bench scenarios: the scaled match arithmetic, the 2^PS stretching of the period, the 25 % case on the 61439 modulo, and a mid-period duty write leaving the current falling edge in place. The behavioural reference model compared every cycle covers the transitions between these scenarios.

// File: rtl/pwm_timer_pkg.sv
// Shared widths and register selects for the PWM timer channel.
package pwm_timer_pkg;
    localparam int CNT_W  = 16;
    localparam int PS_W   = 3;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MODULO = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_RES    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pwm_regs.sv
// Register file of the channel: modulo, control, duty and resolution.
// Assumes one write per cycle; fields are taken from the low data bits.
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int CW    = CNT_W,
    parameter int PW    = PS_W,
    parameter int RW    = $clog2(CW + 1),
    parameter int RES_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW:0]       wr_data,
    output logic [CW-1:0]     mod_q,
    output logic              en_q,
    output logic [PW-1:0]     ps_q,
    output logic [CW:0]       duty_q,
    output logic [RW-1:0]     res_q
);
    // Capture a field write into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q  <= '1;
            en_q   <= 1'b0;
            ps_q   <= '0;
            duty_q <= '0;
            res_q  <= RW'(RES_RST);
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_MODULO: mod_q  <= wr_data[CW-1:0];
                SEL_CTRL: begin
                    en_q <= wr_data[0];
                    ps_q <= wr_data[PW:1];
                end
                SEL_DUTY:   duty_q <= wr_data;
                SEL_RES:    res_q  <= wr_data[RW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_prescaler.sv
// Power-of-two tick generator: one tick every 2^ps cycles while enabled.
// Assumes ps is held constant while enabled; cleared when disabled.
module pwm_prescaler #(
    parameter int PW = 3,
    localparam int DIV_W = (1 << PW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] ps,
    output logic          tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low ps bits all set marks the last cycle of a tick interval.
    always_comb begin
        mask = ~({DIV_W{1'b1}} << ps);
        tick = en && ((div_q & mask) == mask);
    end

    // Free-running divider, held at zero while the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/pwm_scaler.sv
// Scales a duty request onto the counter range:
// (duty * (modulo + 1)) >> res, saturated to the match width.
// Pure combinational; result may exceed the modulo (full-high case).
module pwm_scaler #(
    parameter int CW = 16,
    parameter int RW = 5,
    localparam int PROD_W = 2 * (CW + 1)
) (
    input  logic [CW-1:0] mod_val,
    input  logic [CW:0]   duty,
    input  logic [RW-1:0] res,
    output logic [CW:0]   match_calc
);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;

    // Multiply, shift and clamp to the match register width.
    always_comb begin
        prod    = PROD_W'(duty) * PROD_W'({1'b0, mod_val} + (CW + 1)'(1));
        shifted = prod >> res;
        if (|shifted[PROD_W-1:CW+1]) match_calc = '1;
        else                         match_calc = shifted[CW:0];
    end
endmodule

// File: rtl/pwm_counter.sv
// Up-counter with modulo wrap, shadowed match register and edge-aligned
// high-true compare. The match value is adopted while disabled and at wrap.
module pwm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] mod_val,
    input  logic [CW:0]   match_calc,
    output logic [CW-1:0] cnt_q,
    output logic [CW:0]   match_q,
    output logic          pwm
);
    logic wrap;

    // A tick at or past the modulo ends the period.
    assign wrap = tick && (cnt_q >= mod_val);

    // Count ticks, restarting at zero after the modulo.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (wrap)     cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + 1'b1;
    end

    // Adopt the freshly scaled match value only between periods.
    always_ff @(posedge clk) begin
        if (!rst_n)          match_q <= '0;
        else if (!en || wrap) match_q <= match_calc;
    end

    // High from the restart until the counter reaches the match value.
    assign pwm = en && ({1'b0, cnt_q} < match_q);
endmodule

// File: rtl/pwm_timer_chan.sv
// Top of the edge-aligned PWM timer channel: register port, prescaler,
// duty scaler and counter/compare. Synchronous active-low reset.
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PS_W,
    localparam int RW = $clog2(CW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW:0]       wr_data,
    output logic              pwm_o
);
    logic [CW-1:0] mod_q;
    logic          en_q;
    logic [PW-1:0] ps_q;
    logic [CW:0]   duty_q;
    logic [RW-1:0] res_q;
    logic          tick;
    logic [CW:0]   match_calc;
    logic [CW-1:0] cnt_q;
    logic [CW:0]   match_q;

    pwm_regs #(.CW(CW), .PW(PW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mod_q(mod_q), .en_q(en_q), .ps_q(ps_q),
        .duty_q(duty_q), .res_q(res_q)
    );

    pwm_prescaler #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en_q), .ps(ps_q), .tick(tick)
    );

    pwm_scaler #(.CW(CW), .RW(RW)) u_scale (
        .mod_val(mod_q), .duty(duty_q), .res(res_q), .match_calc(match_calc)
    );

    pwm_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .mod_val(mod_q),
        .match_calc(match_calc), .cnt_q(cnt_q), .match_q(match_q), .pwm(pwm_o)
    );
endmodule

// File: rtl/pwm_timer_chan_chk.sv
// Property checker for the PWM timer channel, bound to the top module.
module pwm_timer_chan_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_q,
    input logic          tick,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] mod_q,
    input logic [CW:0]   match_q,
    input logic          pwm_o
);
    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pwm_o);

    p_off_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> cnt_q == '0);

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick && cnt_q < mod_q) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick && cnt_q >= mod_q) |=> cnt_q == '0);

    p_hold_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !tick) |=> $stable(cnt_q));

    p_match_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !(tick && cnt_q >= mod_q)) |=> $stable(match_q));

    p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_q == '0 |-> !pwm_o);

    p_over_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && cnt_q <= mod_q && match_q > {1'b0, mod_q}) |-> pwm_o);

    p_rise_at_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> cnt_q == '0);
endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .tick(tick), .cnt_q(cnt_q),
    .mod_q(mod_q), .match_q(match_q), .pwm_o(pwm_o)
);

// File: tb/sim_pwm_timer_chan.sv
module sim_pwm_timer_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [16:0] wr_data = '0;
    logic        pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pwm_timer_chan u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o));

    always #4 clk = ~clk;   // 125 MHz

    // Behavioural reference state
    int m_mod, m_en, m_ps, m_duty, m_res, m_pre, m_cnt, m_match;

    function automatic int scale(int d, int m, int r);
        longint p;
        p = (longint'(d) * longint'(m + 1)) >>> r;
        if (p > 131071) p = 131071;
        return int'(p);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mod = 65535; m_en = 0; m_ps = 0; m_duty = 0; m_res = 8;
            m_pre = 0; m_cnt = 0; m_match = 0;
        end else begin
            if (m_en == 0) begin
                m_pre = 0; m_cnt = 0; m_match = scale(m_duty, m_mod, m_res);
            end else if (m_pre == (1 << m_ps) - 1) begin
                m_pre = 0;
                if (m_cnt >= m_mod) begin
                    m_cnt = 0; m_match = scale(m_duty, m_mod, m_res);
                end else m_cnt++;
            end else m_pre++;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_mod = int'(wr_data[15:0]);
                    2'd1: begin m_en = int'(wr_data[0]); m_ps = int'(wr_data[3:1]); end
                    2'd2: m_duty = int'(wr_data);
                    default: m_res = int'(wr_data[4:0]);
                endcase
            end
        end
    end

    // Per-cycle comparison against the model (R3 output rule)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic exp_o;
            exp_o = (m_en != 0) && (m_cnt < m_match);
            checks++;
            if (pwm_o !== exp_o) begin
                errors++;
                $display("FAIL R3 cycle compare: pwm_o=%0b expected %0b", pwm_o, exp_o);
            end
        end
    end

    task automatic check(string req, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 17'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count high samples over n cycles, starting at the current negedge
    task automatic count_high(int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_o) hi++;
            @(negedge clk);
        end
    endtask

    // Disable, program, enable; measure the first full period
    task automatic run_period(string req, int md, int ps, int du, int rs);
        int hi, mt, exp_hi;
        wr(1, 0);
        wr(0, md); wr(3, rs); wr(2, du);
        wr(1, (ps << 1) | 1);
        count_high((md + 1) << ps, hi);
        mt = scale(du, md, rs);
        exp_hi = ((mt > md + 1) ? md + 1 : mt) << ps;
        check(req, hi, exp_hi);
    endtask

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset output low", int'(pwm_o), 0);
        count_high(20, hi);
        check("R9 idle stays low", hi, 0);

        run_period("R4 half duty mod 99", 99, 0, 128, 8);
        check("R4 scaled match", scale(128, 99, 8), 50);
        run_period("R5 zero duty", 99, 0, 0, 8);
        run_period("R6 full duty res8", 99, 0, 256, 8);
        run_period("R6 full duty res4", 37, 0, 16, 4);
        run_period("R7 over-range duty", 99, 0, 300, 8);
        run_period("R2 prescale 4", 99, 2, 128, 8);
        run_period("R2 prescale 128", 9, 7, 3, 2);
        run_period("R1 small modulo", 4, 0, 100, 8);
        run_period("R4 odd scaling res10", 1000, 1, 333, 10);

        // R8: rewrite duty after the falling edge; old period must finish
        run_period("R8 setup", 99, 0, 128, 8);
        while (!pwm_o) @(negedge clk);
        while (pwm_o)  @(negedge clk);
        wr(2, 200);
        count_high(40, hi);
        check("R8 current period unchanged", hi, 0);
        while (!pwm_o) @(negedge clk);
        count_high(100, hi);
        check("R8 new duty next period", hi, scale(200, 99, 8));

        // R9: disabling drops the line
        wr(1, 0);
        count_high(10, hi);
        check("R9 disabled low", hi, 0);

        // R10: 25 % on a 61439 modulo
        run_period("R10 quarter duty", 61439, 0, 64, 8);
        check("R10 match value", scale(64, 61439, 8), 15360);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule